// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is a bus master for an external bus on which one set of pins carries different information in different clocks. The low eight lines carry the low address byte at the start of a cycle and data after that. The top four lines carry the top address nibble and then status. A core presents a transfer request with a 20-bit address, a memory-or-I/O select, a read or write flag, a write byte and a 2-bit segment tag. The block runs one bus cycle of four phases, T1 to T4, with optional wait phases between T3 and T4. During the cycle it drives the address latch strobe, the read and write strobes, the memory/I/O select and the transceiver enable and direction.

A read returns the byte sampled from the bus, and a one-clock done pulse marks the end of every transfer. The middle address byte (bits 15:8) stays on its own lines for the whole cycle. The core sees a combinational accept signal. A request is taken only when the bus is free, either in idle or in the last phase of a cycle, so transfers can follow each other with no idle clock between them.

Top module: `mbus_seq`

## Requirements
- R1: In and after reset with no request, the bus is idle: ALE low, read, write and transceiver-enable strobes high (inactive), direction high, memory/I/O select low, low lines not driven, done low.
- R2: In T1 the low lines are driven with address bits 7:0 and the top lines carry address bits 19:16. The middle lines carry address bits 15:8 from T1 through T4.
- R3: From T2 through T4 the top lines carry status: bit 0 is segment tag bit 0, bit 1 is segment tag bit 1, bits 3:2 are zero.
- R4: For a write, the write strobe is low and the low lines drive the write byte from T2 through T3 and any wait phase. The read strobe stays high.
- R5: For a read, the read strobe is low from T2 through T3 and any wait phase, and the low lines are not driven. The byte returned is the one present on the bus input in the last clock before T4.
- R6: In T4 the read, write and transceiver-enable strobes and the direction line are all high, and the low lines are released.
- R7: ALE is high for exactly the single T1 clock of each cycle and low otherwise.
- R8: The memory/I/O select equals the request's select (high = I/O) from T1 through T4.
- R9: The direction line equals the write flag from T1 through the last data clock, and the transceiver enable is low from T2 through the last data clock.
- R10: READY low at the end of T3 or of a wait phase adds one more wait phase with every T3 output held, so a cycle lasts 4 + n clocks for n wait phases.
- R11: Done is high for exactly one clock, the clock after T4, and the read data is valid in that clock.
- R12: A request is accepted in idle or in T4. An accepted request in T4 starts T1 on the very next clock.
- R13: A request raised during T1 to T3 is not accepted and does not disturb the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_addr | input | 20 | Transfer address |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| req_seg | input | 2 | Segment tag shown as status |
| req_accept | output | 1 | Request taken at this clock edge |
| bus_ready | input | 1 | Device ready; low adds wait phases |
| bus_ad_in | input | 8 | Bus low lines as seen from the pins |
| bus_ad_out | output | 8 | Value driven on the low lines |
| bus_ad_oe | output | 1 | Output enable for the low lines |
| bus_mid | output | 8 | Address bits 15:8 |
| bus_hi | output | 4 | Address bits 19:16, then status |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io_m | output | 1 | High = I/O, low = memory |
| bus_den_n | output | 1 | Transceiver enable, active low |
| bus_dt_r | output | 1 | Transceiver direction, high = transmit |
| done | output | 1 | One-clock end-of-transfer pulse |
| rdata | output | 8 | Byte returned by the last read |

## Verification
An accepted request puts T1 on the bus one clock edge later. The strobes fall one edge after that, and T4 follows two edges later plus one edge per wait phase. Done and read data come one edge after T4. The bench drives every input on the falling edge and checks each phase's outputs on the falling edge inside that phase. When the T4 phase is checked, it logs the clock count in which done is due, and the scoreboard compares the done clock and read data against that entry. Read data on the bus is held wrong in every clock except the last one before T4, so data sampled one clock early or late shows up as a mismatch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4
    } phase_e;

endpackage

// File: rtl/mbus_phase.sv
module mbus_phase
    import mbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   bus_ready,
    output phase_e phase,
    output logic   start
);

    typedef struct packed {
        phase_e ph;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        start = req_valid && (ctl_q.ph == PH_IDLE || ctl_q.ph == PH_T4);
        unique case (ctl_q.ph)
            PH_IDLE: if (start) ctl_d.ph = PH_T1;
            PH_T1:   ctl_d.ph = PH_T2;
            PH_T2:   ctl_d.ph = PH_T3;
            PH_T3:   ctl_d.ph = bus_ready ? PH_T4 : PH_TW;
            PH_TW:   ctl_d.ph = bus_ready ? PH_T4 : PH_TW;
            PH_T4:   ctl_d.ph = start ? PH_T1 : PH_IDLE;
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{ph: PH_IDLE};
        else        ctl_q <= ctl_d;
    end

    assign phase = ctl_q.ph;

    // T1 is only ever entered from an accepted request
    assert_t1_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |-> $past(start));

    // a wait phase always follows T3 or another wait phase with READY low
    assert_wait_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TW) |-> !$past(bus_ready));

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int SEG_W  = 2,
    parameter int HI_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_e             phase,
    input  logic               start,
    input  logic               bus_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_io,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [DATA_W-1:0]  bus_ad_in,
    output logic [DATA_W-1:0]  bus_ad_out,
    output logic               bus_ad_oe,
    output logic [ADDR_W-DATA_W-HI_W-1:0] bus_mid,
    output logic [HI_W-1:0]    bus_hi,
    output logic               bus_ale,
    output logic               bus_rd_n,
    output logic               bus_wr_n,
    output logic               bus_io_m,
    output logic               bus_den_n,
    output logic               bus_dt_r,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);

    localparam int MID_W  = ADDR_W - DATA_W - HI_W;
    localparam int HI_LO  = ADDR_W - HI_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              io;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [SEG_W-1:0]  seg;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } xfer_t;

    xfer_t x_d, x_q;

    logic            in_t1, in_data, in_t4, active;
    logic [HI_W-1:0] status;

    assign in_t1   = (phase == PH_T1);
    assign in_data = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
    assign in_t4   = (phase == PH_T4);
    assign active  = in_t1 || in_data || in_t4;

    generate
        if (HI_W > SEG_W) begin : g_pad_status
            assign status = {{(HI_W-SEG_W){1'b0}}, x_q.seg};
        end else begin : g_full_status
            assign status = x_q.seg[HI_W-1:0];
        end
    endgenerate

    // next-state
    always_comb begin
        x_d      = x_q;
        x_d.done = in_t4;
        if (start) begin
            x_d.addr  = req_addr;
            x_d.io    = req_io;
            x_d.wr    = req_write;
            x_d.wdata = req_wdata;
            x_d.seg   = req_seg;
        end
        if ((phase == PH_T3 || phase == PH_TW) && bus_ready && !x_q.wr) begin
            x_d.rdata = bus_ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    // bus line decode from the phase register and the latched request
    always_comb begin
        bus_ale    = in_t1;
        bus_ad_oe  = in_t1 || (in_data && x_q.wr);
        bus_ad_out = '0;
        if (in_t1)                 bus_ad_out = x_q.addr[DATA_W-1:0];
        else if (in_data && x_q.wr) bus_ad_out = x_q.wdata;
        bus_mid    = active ? x_q.addr[HI_LO-1:DATA_W] : '0;
        bus_hi     = '0;
        if (in_t1)                 bus_hi = x_q.addr[ADDR_W-1:HI_LO];
        else if (in_data || in_t4) bus_hi = status;
        bus_io_m   = active && x_q.io;
        bus_dt_r   = (in_t1 || in_data) ? x_q.wr : 1'b1;
        bus_den_n  = !in_data;
        bus_rd_n   = !(in_data && !x_q.wr);
        bus_wr_n   = !(in_data && x_q.wr);
    end

    assign done  = x_q.done;
    assign rdata = x_q.rdata;

    assert_ale_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TW) |-> ($stable(bus_ad_out) && $stable(bus_rd_n) &&
                              $stable(bus_wr_n) && $stable(bus_hi) &&
                              $stable(bus_den_n) && $stable(bus_dt_r)));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_den_n) |-> (in_t4 && bus_rd_n && bus_wr_n && !bus_ad_oe));

    assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_t4 |=> done);

    assert_iom_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data || in_t4) |-> $stable(bus_io_m));

    assert_mid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data || in_t4) |-> $stable(bus_mid));

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int SEG_W  = 2,
    parameter int HI_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_io,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [SEG_W-1:0]   req_seg,
    output logic               req_accept,
    input  logic               bus_ready,
    input  logic [DATA_W-1:0]  bus_ad_in,
    output logic [DATA_W-1:0]  bus_ad_out,
    output logic               bus_ad_oe,
    output logic [ADDR_W-DATA_W-HI_W-1:0] bus_mid,
    output logic [HI_W-1:0]    bus_hi,
    output logic               bus_ale,
    output logic               bus_rd_n,
    output logic               bus_wr_n,
    output logic               bus_io_m,
    output logic               bus_den_n,
    output logic               bus_dt_r,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);

    phase_e phase;
    logic   start;

    mbus_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .phase     (phase),
        .start     (start)
    );

    mbus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEG_W  (SEG_W),
        .HI_W   (HI_W)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .start      (start),
        .bus_ready  (bus_ready),
        .req_addr   (req_addr),
        .req_io     (req_io),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .req_seg    (req_seg),
        .bus_ad_in  (bus_ad_in),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_mid    (bus_mid),
        .bus_hi     (bus_hi),
        .bus_ale    (bus_ale),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_io_m   (bus_io_m),
        .bus_den_n  (bus_den_n),
        .bus_dt_r   (bus_dt_r),
        .done       (done),
        .rdata      (rdata)
    );

    assign req_accept = start;

endmodule

// File: tb/mbus_seq_test.sv
module mbus_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [19:0] req_addr;
    logic        req_io;
    logic        req_write;
    logic [7:0]  req_wdata;
    logic [1:0]  req_seg;
    logic        req_accept;
    logic        bus_ready;
    logic [7:0]  bus_ad_in;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_mid;
    logic [3:0]  bus_hi;
    logic        bus_ale, bus_rd_n, bus_wr_n, bus_io_m, bus_den_n, bus_dt_r;
    logic        done;
    logic [7:0]  rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_io(req_io),
        .req_write(req_write), .req_wdata(req_wdata), .req_seg(req_seg),
        .req_accept(req_accept),
        .bus_ready(bus_ready), .bus_ad_in(bus_ad_in),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_mid(bus_mid), .bus_hi(bus_hi), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_io_m(bus_io_m),
        .bus_den_n(bus_den_n), .bus_dt_r(bus_dt_r),
        .done(done), .rdata(rdata)
    );

    typedef struct {
        bit         is_rd;
        logic [7:0] val;
        int         due;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   cyc   = 0;
    bit   prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (rst_n === 1'b1) begin
            if (done) begin
                if (prev_done) chk("R11 done wider than one clock", 1, 0);
                if (sb.size() == 0) begin
                    chk("R11 done without a transfer", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk("R11 done clock", cyc, e.due);
                    if (e.is_rd) chk("R5 read data", rdata, e.val);
                end
            end
            prev_done = done;
        end
    end

    task automatic check_idle(input string tag);
        chk({tag, " ale"},   bus_ale,   0);
        chk({tag, " rd_n"},  bus_rd_n,  1);
        chk({tag, " wr_n"},  bus_wr_n,  1);
        chk({tag, " den_n"}, bus_den_n, 1);
        chk({tag, " dt_r"},  bus_dt_r,  1);
        chk({tag, " io_m"},  bus_io_m,  0);
        chk({tag, " oe"},    bus_ad_oe, 0);
        chk({tag, " done"},  done,      0);
    endtask

    task automatic check_data(input logic [19:0] a, input logic io, input logic wr,
                              input logic [7:0] wd, input logic [1:0] sg);
        chk("R7 ale low in data phase", bus_ale, 0);
        chk("R3 status lines", bus_hi, {2'b00, sg});
        chk("R2 middle address held", bus_mid, a[15:8]);
        chk("R8 io_m held", bus_io_m, io);
        chk("R9 direction", bus_dt_r, wr);
        chk("R9 transceiver enable", bus_den_n, 0);
        if (wr) begin
            chk("R4 wr_n low", bus_wr_n, 0);
            chk("R4 rd_n high", bus_rd_n, 1);
            chk("R4 low lines driven", bus_ad_oe, 1);
            chk("R4 write byte", bus_ad_out, wd);
        end else begin
            chk("R5 rd_n low", bus_rd_n, 0);
            chk("R5 wr_n high", bus_wr_n, 1);
            chk("R5 low lines released", bus_ad_oe, 0);
        end
    endtask

    // driver: presents a request at the current falling edge, walks the cycle,
    // returns at the falling edge inside T4
    task automatic xfer(input logic [19:0] a, input logic io, input logic wr,
                        input logic [7:0] wd, input logic [1:0] sg,
                        input int waits, input logic [7:0] rv, input bit poke);
        exp_t e;
        req_valid = 1'b1; req_addr = a; req_io = io; req_write = wr;
        req_wdata = wd;   req_seg = sg;
        bus_ready = 1'b1; bus_ad_in = ~rv;
        #1;
        chk("R12 accept when bus free", req_accept, 1);
        @(negedge clk);                       // T1
        req_valid = 1'b0;
        req_addr = 20'h0; req_wdata = 8'h0; req_seg = 2'b00;
        chk("R7 ale high in T1", bus_ale, 1);
        chk("R2 low lines address", bus_ad_out, a[7:0]);
        chk("R2 low lines driven", bus_ad_oe, 1);
        chk("R2 top lines address", bus_hi, a[19:16]);
        chk("R2 middle address", bus_mid, a[15:8]);
        chk("R8 io_m in T1", bus_io_m, io);
        chk("R9 direction in T1", bus_dt_r, wr);
        chk("R9 strobes idle in T1", {bus_rd_n, bus_wr_n, bus_den_n}, 3'b111);
        @(negedge clk);                       // T2
        if (poke) begin
            req_valid = 1'b1; req_addr = ~a; req_io = ~io; req_write = ~wr;
            req_seg = ~sg;
            #1;
            chk("R13 no accept mid-cycle", req_accept, 0);
        end
        check_data(a, io, wr, wd, sg);
        @(negedge clk);                       // T3
        if (poke) begin
            chk("R13 cycle undisturbed", bus_mid, a[15:8]);
            req_valid = 1'b0;
        end
        bus_ready = (waits == 0);
        bus_ad_in = (waits == 0) ? rv : ~rv;
        check_data(a, io, wr, wd, sg);
        for (int i = 1; i <= waits; i++) begin
            @(negedge clk);                   // wait phase
            bus_ready = (i == waits);
            bus_ad_in = (i == waits) ? rv : ~rv;
            chk("R10 strobe held in wait", wr ? bus_wr_n : bus_rd_n, 0);
            check_data(a, io, wr, wd, sg);
        end
        @(negedge clk);                       // T4
        bus_ready = 1'b1; bus_ad_in = ~rv;
        chk("R6 strobes released", {bus_rd_n, bus_wr_n, bus_den_n, bus_dt_r}, 4'b1111);
        chk("R6 low lines released", bus_ad_oe, 0);
        chk("R7 ale low in T4", bus_ale, 0);
        chk("R3 status in T4", bus_hi, {2'b00, sg});
        chk("R8 io_m in T4", bus_io_m, io);
        chk("R2 middle address in T4", bus_mid, a[15:8]);
        e.is_rd = !wr; e.val = rv; e.due = cyc + 1;
        sb.push_back(e);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_io = 1'b0;
        req_write = 1'b0; req_wdata = '0; req_seg = '0;
        bus_ready = 1'b1; bus_ad_in = '0;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        chk("R1 no accept without request", req_accept, 0);

        xfer(20'hA5C3E, 1'b0, 1'b0, 8'h00, 2'b10, 0, 8'h5A, 1'b0);   // memory read
        @(negedge clk);
        xfer(20'h312F0, 1'b1, 1'b1, 8'hC3, 2'b01, 0, 8'h00, 1'b0);   // I/O write
        @(negedge clk);
        xfer(20'hF0081, 1'b0, 1'b1, 8'h7E, 2'b11, 2, 8'h00, 1'b0);   // R10 write, 2 waits
        @(negedge clk);
        xfer(20'h6BDA4, 1'b1, 1'b0, 8'h00, 2'b00, 3, 8'h96, 1'b0);   // R10 read, 3 waits
        @(negedge clk);
        // R12 back-to-back: second request presented during T4 of the first
        xfer(20'h0FF11, 1'b0, 1'b0, 8'h00, 2'b01, 0, 8'hE1, 1'b0);
        xfer(20'h9A0B7, 1'b0, 1'b1, 8'h3C, 2'b10, 1, 8'h00, 1'b0);
        @(negedge clk);
        // R13 request raised during the cycle is ignored
        xfer(20'h54321, 1'b0, 1'b0, 8'h00, 2'b11, 0, 8'h2D, 1'b1);
        repeat (3) @(negedge clk);
        check_idle("R1 idle after traffic");
        chk("R11 every transfer completed", sb.size(), 0);
        finish_run();
    end

endmodule